// File: doc/BRIEF.md
# Fault-Only-First Vector Load Sequencer

This block steps through the element accesses of a single vector load, from element 0 up to a requested length, one element at a time. For each element the memory side answers with one of three response kinds: the data arrived, the access faulted, or the access is a long-latency miss. The block returns a trimmed vector length, a mask of the elements that finished, a trap request with the index of the faulting element, and a one-cycle done pulse.

Only element 0 must either complete or trap, which keeps forward progress. Past element 0, a fault always ends the load early with the length cut to the number of finished elements. A long-latency miss can also end it early when trimming on misses is enabled. An optional zero-length mode lets an element-0 fault return length 0 instead of trapping. A counter of back-to-back zero-length results bounds this mode, and a chicken-bit input drops its allowance to zero.

Top module: `ff_load_seq`

## Requirements
- R1: When every element returns response kind 0 (done), `outLen` equals the requested length and `doneMask` bits 0 to length-1 are set, with all other bits clear.
- R2: A response kind 1 (fault) on element i with i > 0 ends the load without a trap, with `outLen` = i and only mask bits below i set.
- R3: A fault on element 0 with zero-length mode off raises `trap` for exactly one cycle, together with `done`, with `trapIdx` = 0, `outLen` equal to the requested length and an empty mask.
- R4: With `trimOnMiss` = 1, a response kind 2 (miss) on element i > 0 ends the load with `outLen` = i. A miss on element 0 only waits for a later response.
- R5: With `trimOnMiss` = 0, a miss response has no effect, and the load goes on with the same element.
- R6: With `zeroLenMode` = 1 and `chickenBit` = 0, an element-0 fault returns `outLen` = 0 without a trap for up to 10 back-to-back zero-length results. The 11th such fault traps.
- R7: Any result other than a zero-length one, a trap included, clears the zero-length counter.
- R8: With `chickenBit` = 1, an element-0 fault traps at once, even in zero-length mode.
- R9: A start with requested length 0 gives `done` in the next cycle, with `outLen` = 0, no element access, no trap and no change to the zero-length counter.
- R10: After reset, `done`, `trap`, `elemReq`, `outLen` and `doneMask` are 0. While a load runs, `elemReq` is high and `elemIdx` names the next element, and `done` rises in the cycle after the final response is accepted.
- R11: A start pulse while a load is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken only when idle) |
| reqLen | input | VLW | Requested vector length, 0 to MAX_VL |
| trimOnMiss | input | 1 | Allow stopping at a long-latency miss |
| zeroLenMode | input | 1 | Allow zero-length results on an element-0 fault |
| chickenBit | input | 1 | Force the zero-length allowance to zero |
| elemReq | output | 1 | Element access outstanding |
| elemIdx | output | IDXW | Index of the element being accessed |
| respValid | input | 1 | Memory response present this cycle |
| respKind | input | 2 | 0 done, 1 fault, 2 long-latency miss, 3 no effect |
| outLen | output | VLW | Trimmed vector length |
| doneMask | output | MAX_VL | One bit per finished element |
| trap | output | 1 | Trap request pulse |
| trapIdx | output | IDXW | Faulting element index for the trap |
| done | output | 1 | Load finished pulse |

## Verification
The bench uses MAX_VL = 8 and ZL_LIMIT = 10. With MAX_VL = 8, a run at full width sets every mask bit, and the 4-bit length field reaches its top value of 8. With ZL_LIMIT = 10, the exact bound is exercised: ten zero-length results followed by the trapping eleventh. The same bound is exercised again after a clearing result and after an interleaved length-0 start.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
  typedef enum logic [1:0] {
    RESP_DONE  = 2'd0,
    RESP_FAULT = 2'd1,
    RESP_MISS  = 2'd2,
    RESP_NONE  = 2'd3
  } respKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture length, clear index and mask
    logic accept;   // current element finished
    logic finCur;   // result length = current index
    logic finReq;   // result length = requested length
    logic finZero;  // result length = 0
  } dpStrobe_t;
endpackage

// File: rtl/ffl_dp.sv
module ffl_dp
  import ffl_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int VLW    = $clog2(MAX_VL + 1),
  parameter int IDXW   = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [VLW-1:0]    reqLen,
  output logic [IDXW-1:0]   curIdx,
  output logic              firstElem,
  output logic              lastElem,
  output logic [VLW-1:0]    outLen,
  output logic [MAX_VL-1:0] doneMask
);
  logic [VLW-1:0]    lenReg;
  logic [VLW-1:0]    curReg;
  logic [VLW-1:0]    outLenReg;
  logic [MAX_VL-1:0] maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg <= '0;
      curReg <= '0;
    end else if (stb.load) begin
      lenReg <= reqLen;
      curReg <= '0;
    end else if (stb.accept) begin
      curReg <= curReg + VLW'(1);
    end
  end

  for (genvar i = 0; i < MAX_VL; i++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) maskReg[i] <= 1'b0;
      else if (stb.load) maskReg[i] <= 1'b0;
      else if (stb.accept && curReg == VLW'(i)) maskReg[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outLenReg <= '0;
    else if (stb.finZero) outLenReg <= '0;
    else if (stb.finReq) outLenReg <= lenReg;
    else if (stb.finCur) outLenReg <= curReg;
  end

  assign curIdx    = curReg[IDXW-1:0];
  assign firstElem = (curReg == '0);
  assign lastElem  = ((curReg + VLW'(1)) == lenReg);
  assign outLen    = outLenReg;
  assign doneMask  = maskReg;

  // finished elements always form a prefix starting at element 0
  assert_mask_prefix_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((maskReg & (maskReg + MAX_VL'(1))) == '0));
  // a trimmed length never exceeds the vector width
  assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outLenReg <= VLW'(MAX_VL)));
endmodule

// File: rtl/ffl_ctrl.sv
module ffl_ctrl
  import ffl_pkg::*;
#(
  parameter int MAX_VL   = 8,
  parameter int ZL_LIMIT = 10,
  parameter int IDXW     = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  parameter int ZLW      = $clog2(ZL_LIMIT + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            reqLenZero,
  input  logic            trimOnMiss,
  input  logic            zeroLenMode,
  input  logic            chickenBit,
  input  logic            respValid,
  input  logic [1:0]      respKind,
  input  logic [IDXW-1:0] curIdx,
  input  logic            firstElem,
  input  logic            lastElem,
  output dpStrobe_t       stb,
  output logic            busy,
  output logic            done,
  output logic            trap,
  output logic [IDXW-1:0] trapIdx
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;
  state_e stateQ, stateD;
  logic [ZLW-1:0] zlCount;
  logic finish, trapNow, zlInc, zlClr, zlAllowed;

  assign zlAllowed = zeroLenMode && !chickenBit && (zlCount < ZLW'(ZL_LIMIT));
  assign busy = (stateQ == ST_BUSY);

  always_comb begin
    stb     = '0;
    stateD  = stateQ;
    finish  = 1'b0;
    trapNow = 1'b0;
    zlInc   = 1'b0;
    zlClr   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          if (reqLenZero) begin
            stb.finZero = 1'b1;
            finish      = 1'b1;
          end else begin
            stateD = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (respValid) begin
          unique case (respKind_e'(respKind))
            RESP_DONE: begin
              stb.accept = 1'b1;
              if (lastElem) begin
                stb.finReq = 1'b1;
                finish     = 1'b1;
              end
            end
            RESP_FAULT: begin
              finish = 1'b1;
              if (!firstElem) stb.finCur = 1'b1;
              else if (zlAllowed) begin
                stb.finZero = 1'b1;
                zlInc       = 1'b1;
              end else begin
                stb.finReq = 1'b1;
                trapNow    = 1'b1;
              end
            end
            RESP_MISS: begin
              if (!firstElem && trimOnMiss) begin
                stb.finCur = 1'b1;
                finish     = 1'b1;
              end
            end
            default: ;
          endcase
          if (finish) begin
            stateD = ST_IDLE;
            zlClr  = !zlInc;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      zlCount <= '0;
      done    <= 1'b0;
      trap    <= 1'b0;
      trapIdx <= '0;
    end else begin
      stateQ  <= stateD;
      done    <= finish;
      trap    <= trapNow;
      if (trapNow) trapIdx <= curIdx;
      if (zlInc) zlCount <= zlCount + ZLW'(1);
      else if (zlClr) zlCount <= '0;
    end
  end

  assert_trap_with_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> done);
  assert_trap_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    trap |=> !trap);
  assert_zl_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    zlCount <= ZLW'(ZL_LIMIT));
  assert_chicken_traps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && respValid && respKind == 2'd1 && firstElem && chickenBit) |=> trap);
  assert_empty_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && reqLenZero) |=> (done && !trap && !busy));
  assert_no_done_while_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
endmodule

// File: rtl/ff_load_seq.sv
module ff_load_seq
  import ffl_pkg::*;
#(
  parameter int MAX_VL   = 8,
  parameter int ZL_LIMIT = 10,
  localparam int VLW     = $clog2(MAX_VL + 1),
  localparam int IDXW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VLW-1:0]    reqLen,
  input  logic              trimOnMiss,
  input  logic              zeroLenMode,
  input  logic              chickenBit,
  output logic              elemReq,
  output logic [IDXW-1:0]   elemIdx,
  input  logic              respValid,
  input  logic [1:0]        respKind,
  output logic [VLW-1:0]    outLen,
  output logic [MAX_VL-1:0] doneMask,
  output logic              trap,
  output logic [IDXW-1:0]   trapIdx,
  output logic              done
);
  dpStrobe_t stb;
  logic firstElem, lastElem;

  ffl_ctrl #(.MAX_VL(MAX_VL), .ZL_LIMIT(ZL_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .reqLenZero(reqLen == '0),
    .trimOnMiss(trimOnMiss), .zeroLenMode(zeroLenMode), .chickenBit(chickenBit),
    .respValid(respValid), .respKind(respKind), .curIdx(elemIdx),
    .firstElem(firstElem), .lastElem(lastElem), .stb(stb), .busy(elemReq),
    .done(done), .trap(trap), .trapIdx(trapIdx)
  );

  ffl_dp #(.MAX_VL(MAX_VL)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqLen(reqLen), .curIdx(elemIdx),
    .firstElem(firstElem), .lastElem(lastElem), .outLen(outLen), .doneMask(doneMask)
  );
endmodule

// File: tb/sim_ff_load_seq.sv
module sim_ff_load_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] reqLen = '0;
  logic trimOnMiss = 1'b0, zeroLenMode = 1'b0, chickenBit = 1'b0;
  logic elemReq;
  logic [2:0] elemIdx;
  logic respValid = 1'b0;
  logic [1:0] respKind = 2'd0;
  logic [3:0] outLen;
  logic [7:0] doneMask;
  logic trap;
  logic [2:0] trapIdx;
  logic done;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ff_load_seq #(.MAX_VL(8), .ZL_LIMIT(10)) u0 (.*);

  typedef struct packed {
    logic [3:0]  len;
    logic        trim;
    logic [15:0] resp;    // 2-bit kind per response, response 0 in bits 1:0
    logic [3:0]  expLen;
    logic [7:0]  expMask;
    logic        expTrap;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{4'd8, 1'b0, 16'h0000, 4'd8, 8'hFF, 1'b0},  // R1 all elements finish
    '{4'd5, 1'b0, 16'h0010, 4'd2, 8'h03, 1'b0},  // R2 fault on element 2
    '{4'd4, 1'b0, 16'h0001, 4'd4, 8'h00, 1'b1},  // R3 fault on element 0
    '{4'd6, 1'b1, 16'h0008, 4'd1, 8'h01, 1'b0},  // R4 miss on element 1 trims
    '{4'd6, 1'b0, 16'h0008, 4'd6, 8'h3F, 1'b0},  // R5 miss stalls only
    '{4'd3, 1'b1, 16'h0002, 4'd3, 8'h07, 1'b0},  // R4 miss on element 0 waits
    '{4'd1, 1'b0, 16'h0000, 4'd1, 8'h01, 1'b0},  // R1 single element
    '{4'd8, 1'b1, 16'h0040, 4'd3, 8'h07, 1'b0}   // R2 fault on element 3
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // run one load; poke issues a second start mid-run (must be ignored)
  task automatic runLoad(input vec_t v, input string tag, input bit poke,
                         output logic [3:0] gotLen, output logic [7:0] gotMask,
                         output logic gotTrap);
    int k = 0;
    int expIdx = 0;
    bit fin = 0;
    @(negedge clk);
    reqLen = v.len; trimOnMiss = v.trim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 40 && !fin; cyc++) begin
      if (done) begin
        fin = 1;
        gotLen = outLen; gotMask = doneMask; gotTrap = trap;
        if (trap) check(trapIdx == 3'd0, {tag, " R3 trapIdx"}, trapIdx, 0);
        respValid = 1'b0;
      end else if (elemReq) begin
        check(elemIdx == 3'(expIdx), {tag, " R10 elemIdx"}, elemIdx, expIdx);
        respValid = 1'b1;
        respKind  = (k < 8) ? v.resp[2*k +: 2] : 2'd0;
        if (respKind == 2'd0) expIdx++;
        if (poke && k == 1) begin start = 1'b1; reqLen = 4'd7; end
        else start = 1'b0;
        k++;
        @(negedge clk);
      end else begin
        respValid = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
    respValid = 1'b0;
    if (!fin) begin
      check(1'b0, {tag, " R10 done never rose"}, 0, 1);
      gotLen = '0; gotMask = '0; gotTrap = 1'b0;
    end
  endtask

  task automatic runCheck(input vec_t v, input string tag, input bit poke);
    logic [3:0] l; logic [7:0] m; logic t;
    runLoad(v, tag, poke, l, m, t);
    check(l == v.expLen, {tag, " outLen"}, l, v.expLen);
    check(m == v.expMask, {tag, " doneMask"}, m, v.expMask);
    check(t == v.expTrap, {tag, " trap"}, t, v.expTrap);
  endtask

  localparam vec_t F0 = '{4'd4, 1'b0, 16'h0001, 4'd0, 8'h00, 1'b0};  // element-0 fault, zero result
  localparam vec_t F0T = '{4'd4, 1'b0, 16'h0001, 4'd4, 8'h00, 1'b1}; // element-0 fault, trap
  localparam vec_t OK2 = '{4'd2, 1'b0, 16'h0000, 4'd2, 8'h03, 1'b0};
  localparam vec_t Z0 = '{4'd0, 1'b0, 16'h0000, 4'd0, 8'h00, 1'b0};

  initial begin : watchdog
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R10
    check(done == 0 && trap == 0 && elemReq == 0, "R10 reset flags", {done, trap, elemReq}, 0);
    check(outLen == 0 && doneMask == 0, "R10 reset outputs", doneMask, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) runCheck(VEC[i], $sformatf("vec%0d", i), 1'b0);

    // R11 start while busy is ignored
    runCheck('{4'd3, 1'b0, 16'h0000, 4'd3, 8'h07, 1'b0}, "R11 restart ignored", 1'b1);

    // R9 zero requested length: done next cycle, no access
    @(negedge clk);
    reqLen = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R9 done next cycle", done, 1);
    check(elemReq == 1'b0 && trap == 1'b0, "R9 no access no trap", {elemReq, trap}, 0);
    check(outLen == 4'd0, "R9 outLen", outLen, 0);

    // R6 zero-length mode bound
    zeroLenMode = 1'b1;
    for (int i = 0; i < 10; i++) runCheck(F0, $sformatf("R6 zero result %0d", i), 1'b0);
    runCheck(F0T, "R6 eleventh traps", 1'b0);

    // R7 trap cleared the counter; partial count then a good result clears it
    for (int i = 0; i < 3; i++) runCheck(F0, "R7 after trap", 1'b0);
    runCheck(OK2, "R7 clearing result", 1'b0);
    // R9 a length-0 start must not touch the counter
    for (int i = 0; i < 9; i++) runCheck(F0, "R7 refill", 1'b0);
    runCheck(Z0, "R9 empty in zero mode", 1'b0);
    runCheck(F0, "R9 tenth still allowed", 1'b0);
    runCheck(F0T, "R7 eleventh traps again", 1'b0);

    // R8 chicken bit forces immediate trap
    runCheck(F0, "R8 setup zero result", 1'b0);
    chickenBit = 1'b1;
    runCheck(F0T, "R8 chicken trap", 1'b0);
    chickenBit = 1'b0;
    zeroLenMode = 1'b0;

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule